// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves an address translation miss. When the translation buffer misses, it hands over the virtual address together with the table base register. The walker then reads one descriptor from the first-level table in memory. That descriptor may map a 1 MB section directly. It may instead point to a coarse or fine second-level table, and in that case the walker reads a second descriptor that maps a 64 KB, 4 KB or 1 KB page. The walk ends in one of two ways: a fill record for the translation buffer, or a translation fault that reports the table level where the walk stopped.

Memory is reached through a simple word-read port. The walker raises a request strobe for one cycle with the word address. Memory answers with an acknowledge pulse that carries the read data, no earlier than the cycle after the request. The fill record holds the page-aligned virtual and physical bases, a size code, the access permission bits, the domain and the cacheable/bufferable pair. All result fields stay valid while the one-cycle result strobe is high.

Top module: `xlate_walker`

## Requirements
- R1: While reset is high, and at any time the walker is idle, `busy`, `mem_req`, `fill_valid` and `fault_valid` are all low.
- R2: A `miss_valid` seen while idle starts a walk. In the next cycle `busy` is high and `mem_req` is high with address {ttb[31:14], miss_va[31:20], 2'b00}. Bits 13:0 of `ttb` have no effect.
- R3: The type of a first-level descriptor is taken from bits 1:0: 00 fault, 01 coarse table, 10 section, 11 fine table. Section ends the walk with a fill. Coarse and fine each start a second read.
- R4: A section fill reports vbase = {va[31:20], 20'b0}, pbase = {desc[31:20], 20'b0}, size code 0, permissions desc[11:10], domain desc[8:5] and cacheable/bufferable desc[3:2].
- R5: For a coarse table, the second read address is {l1desc[31:10], va[19:12], 2'b00}.
- R6: For a fine table, the second read address is {l1desc[31:12], va[19:10], 2'b00}.
- R7: The type of a second-level descriptor is taken from bits 1:0: 01 large page (size code 1, base bit 16), 10 small page (size code 2, base bit 12), 11 tiny page (size code 3, base bit 10). Both bases are aligned down to the page size. Permissions come from l2desc[5:4], cacheable/bufferable from l2desc[3:2], and the domain from l1desc[8:5].
- R8: A fault type (00) at level one gives `fault_valid` with `fault_level` = 0 and no fill. A fault type at level two, or a tiny page reached through a coarse table, gives `fault_valid` with `fault_level` = 1 and no fill. `fill_valid` and `fault_valid` are never high together.
- R9: Each table level issues exactly one one-cycle request. `mem_addr` holds still while the walker waits for the acknowledge. A `miss_valid` that arrives during a walk is ignored.
- R10: With an acknowledge L cycles after a request, the result strobe rises L+1 cycles after the request for a one-level walk. For a two-level walk it rises 2L+2 cycles after the first request. The strobe lasts one cycle with `busy` still high, and the walker is idle in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Translation miss, starts a walk when idle |
| miss_va | input | 32 | Virtual address that missed |
| ttb | input | 32 | Table base register (bits 31:14 used) |
| busy | output | 1 | High from the first request through the result cycle |
| mem_req | output | 1 | One-cycle read request strobe |
| mem_addr | output | 32 | Descriptor word address |
| mem_ack | input | 1 | Read acknowledge, at least one cycle after the request |
| mem_rdata | input | 32 | Descriptor data, valid with mem_ack |
| fill_valid | output | 1 | One-cycle fill strobe |
| fill_vbase | output | 32 | Page-aligned virtual base |
| fill_pbase | output | 32 | Page-aligned physical base |
| fill_size | output | 2 | 0 section, 1 large, 2 small, 3 tiny |
| fill_ap | output | 2 | Access permission bits |
| fill_domain | output | 4 | Domain number |
| fill_cb | output | 2 | Cacheable/bufferable bits |
| fault_valid | output | 1 | One-cycle translation fault strobe |
| fault_level | output | 1 | 0 first level, 1 second level |

## Verification
Every result has a fixed place in time, counted from the cycle of the first request. A section fill or a first-level fault comes L+1 cycles after that request, and a result from a two-level walk comes 2L+2 cycles after it, where L is the memory latency. The bench sets L to 1, 2 and 3 across the walks and counts cycles from the miss. It expects the strobe at exactly that count, then checks that the walker is idle one cycle later. Each read address is compared at the moment its request strobe appears, and `mem_addr` is checked on every waiting cycle before the acknowledge.

// File: rtl/xw_pkg.sv
package xw_pkg;

    localparam int ADDR_W         = 32;
    localparam int L1_SHIFT       = 20;  // section size and first-level index position
    localparam int TTB_LO         = 14;  // table base alignment
    localparam int LARGE_SHIFT    = 16;
    localparam int SMALL_SHIFT    = 12;
    localparam int TINY_SHIFT     = 10;
    localparam int COARSE_BASE_LO = 10;
    localparam int FINE_BASE_LO   = 12;
    localparam int AP_SEC_LO      = 10;
    localparam int AP_PAGE_LO     = 4;
    localparam int DOM_LO         = 5;
    localparam int DOM_W          = 4;
    localparam int CB_LO          = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_FILL,
        ST_FAULT
    } walk_state_e;

    typedef enum logic [1:0] {
        L1_FAULT   = 2'b00,
        L1_COARSE  = 2'b01,
        L1_SECTION = 2'b10,
        L1_FINE    = 2'b11
    } l1_kind_e;

    typedef enum logic [1:0] {
        L2_FAULT = 2'b00,
        L2_LARGE = 2'b01,
        L2_SMALL = 2'b10,
        L2_TINY  = 2'b11
    } l2_kind_e;

    typedef enum logic [1:0] {
        SZ_SECTION = 2'd0,
        SZ_LARGE   = 2'd1,
        SZ_SMALL   = 2'd2,
        SZ_TINY    = 2'd3
    } page_size_e;

    typedef struct packed {
        logic [ADDR_W-1:0] vbase;
        logic [ADDR_W-1:0] pbase;
        page_size_e        size;
        logic [1:0]        ap;
        logic [DOM_W-1:0]  domain;
        logic [1:0]        cb;
    } fill_rec_t;

    typedef struct packed {
        logic      fault;
        logic      descend;
        fill_rec_t rec;
    } decode_t;

    function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a,
                                                     input page_size_e sz);
        int sh;
        case (sz)
            SZ_SECTION: sh = L1_SHIFT;
            SZ_LARGE:   sh = LARGE_SHIFT;
            SZ_SMALL:   sh = SMALL_SHIFT;
            default:    sh = TINY_SHIFT;
        endcase
        return a & ({ADDR_W{1'b1}} << sh);
    endfunction

endpackage

// File: rtl/xw_addr_gen.sv
module xw_addr_gen
    import xw_pkg::*;
(
    input  logic [ADDR_W-1:0]                va,
    input  logic [ADDR_W-1:0]                ttb,
    input  logic [ADDR_W-COARSE_BASE_LO-1:0] tbl_base,
    input  logic                             fine_tbl,
    output logic [ADDR_W-1:0]                l1_addr,
    output logic [ADDR_W-1:0]                l2_addr
);
    localparam int FINE_DROP = FINE_BASE_LO - COARSE_BASE_LO;

    logic [ADDR_W-1:0] coarse_addr;
    logic [ADDR_W-1:0] fine_addr;
    logic              unused_addr_bits;

    // word index into the first-level table sits right under the base
    assign l1_addr = {ttb[ADDR_W-1:TTB_LO], va[ADDR_W-1:L1_SHIFT], 2'b00};

    assign coarse_addr = {tbl_base, va[L1_SHIFT-1:SMALL_SHIFT], 2'b00};
    assign fine_addr   = {tbl_base[ADDR_W-COARSE_BASE_LO-1:FINE_DROP],
                          va[L1_SHIFT-1:TINY_SHIFT], 2'b00};

    assign l2_addr = fine_tbl ? fine_addr : coarse_addr;

    assign unused_addr_bits = ^{ttb[TTB_LO-1:0], va[TINY_SHIFT-1:0],
                                tbl_base[FINE_DROP-1:0]};
endmodule

// File: rtl/xw_decode.sv
module xw_decode
    import xw_pkg::*;
(
    input  logic              second,
    input  logic              fine_tbl,
    input  logic [ADDR_W-1:0] va,
    input  logic [DOM_W-1:0]  l1_domain,
    input  logic [ADDR_W-1:0] rdata,
    output decode_t           dec
);
    page_size_e sz;
    logic       page_ok;

    always_comb begin
        dec     = '0;
        sz      = SZ_SMALL;
        page_ok = 1'b0;
        if (!second) begin
            case (l1_kind_e'(rdata[1:0]))
                L1_FAULT: dec.fault = 1'b1;
                L1_SECTION: begin
                    dec.rec.size   = SZ_SECTION;
                    dec.rec.vbase  = align_down(va, SZ_SECTION);
                    dec.rec.pbase  = align_down(rdata, SZ_SECTION);
                    dec.rec.ap     = rdata[AP_SEC_LO +: 2];
                    dec.rec.domain = rdata[DOM_LO +: DOM_W];
                    dec.rec.cb     = rdata[CB_LO +: 2];
                end
                L1_COARSE: dec.descend = 1'b1;
                L1_FINE:   dec.descend = 1'b1;
            endcase
        end else begin
            case (l2_kind_e'(rdata[1:0]))
                L2_FAULT: page_ok = 1'b0;
                L2_LARGE: begin page_ok = 1'b1;     sz = SZ_LARGE; end
                L2_SMALL: begin page_ok = 1'b1;     sz = SZ_SMALL; end
                L2_TINY:  begin page_ok = fine_tbl; sz = SZ_TINY;  end
            endcase
            dec.fault = !page_ok;
            if (page_ok) begin
                dec.rec.size   = sz;
                dec.rec.vbase  = align_down(va, sz);
                dec.rec.pbase  = align_down(rdata, sz);
                dec.rec.ap     = rdata[AP_PAGE_LO +: 2];
                dec.rec.domain = l1_domain;
                dec.rec.cb     = rdata[CB_LO +: 2];
            end
        end
    end
endmodule

// File: rtl/xw_fsm.sv
module xw_fsm
    import xw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        miss_valid,
    input  logic        mem_ack,
    input  logic        dec_fault,
    input  logic        dec_descend,
    output walk_state_e state
);
    walk_state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:    if (miss_valid) nxt = ST_L1_REQ;
            ST_L1_REQ:  nxt = ST_L1_WAIT;
            ST_L1_WAIT: if (mem_ack)
                            nxt = dec_fault   ? ST_FAULT :
                                  dec_descend ? ST_L2_REQ : ST_FILL;
            ST_L2_REQ:  nxt = ST_L2_WAIT;
            ST_L2_WAIT: if (mem_ack) nxt = dec_fault ? ST_FAULT : ST_FILL;
            ST_FILL:    nxt = ST_IDLE;
            ST_FAULT:   nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
    import xw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_va,
    input  logic [ADDR_W-1:0] ttb,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              fill_valid,
    output logic [ADDR_W-1:0] fill_vbase,
    output logic [ADDR_W-1:0] fill_pbase,
    output logic [1:0]        fill_size,
    output logic [1:0]        fill_ap,
    output logic [DOM_W-1:0]  fill_domain,
    output logic [1:0]        fill_cb,
    output logic              fault_valid,
    output logic              fault_level
);
    walk_state_e       state;
    decode_t           dec;
    fill_rec_t         rec_q;
    logic [ADDR_W-1:0] va_q;
    logic [ADDR_W-1:0] ttb_q;
    logic [ADDR_W-1:0] l1_q;
    logic              lvl_q;
    logic [ADDR_W-1:0] l1_addr;
    logic [ADDR_W-1:0] l2_addr;
    logic              fine_tbl;
    logic              in_l1;
    logic              in_l2;
    logic              ack_l1;
    logic              ack_l2;
    logic              unused_l1_bits;

    assign fine_tbl = (l1_kind_e'(l1_q[1:0]) == L1_FINE);
    assign in_l1    = (state == ST_L1_REQ) || (state == ST_L1_WAIT);
    assign in_l2    = (state == ST_L2_REQ) || (state == ST_L2_WAIT);
    assign ack_l1   = (state == ST_L1_WAIT) && mem_ack;
    assign ack_l2   = (state == ST_L2_WAIT) && mem_ack;

    xw_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .miss_valid  (miss_valid),
        .mem_ack     (mem_ack),
        .dec_fault   (dec.fault),
        .dec_descend (dec.descend),
        .state       (state)
    );

    xw_addr_gen u_addr (
        .va       (va_q),
        .ttb      (ttb_q),
        .tbl_base (l1_q[ADDR_W-1:COARSE_BASE_LO]),
        .fine_tbl (fine_tbl),
        .l1_addr  (l1_addr),
        .l2_addr  (l2_addr)
    );

    xw_decode u_dec (
        .second    (state == ST_L2_WAIT),
        .fine_tbl  (fine_tbl),
        .va        (va_q),
        .l1_domain (l1_q[DOM_LO +: DOM_W]),
        .rdata     (mem_rdata),
        .dec       (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            va_q  <= '0;
            ttb_q <= '0;
            l1_q  <= '0;
            lvl_q <= 1'b0;
            rec_q <= '0;
        end else begin
            if (state == ST_IDLE && miss_valid) begin
                va_q  <= miss_va;
                ttb_q <= ttb;
            end
            if (ack_l1) begin
                l1_q  <= mem_rdata;
                lvl_q <= 1'b0;
            end
            if (ack_l2) lvl_q <= 1'b1;
            if ((ack_l1 || ack_l2) && !dec.fault && !dec.descend) rec_q <= dec.rec;
        end
    end

    assign busy        = (state != ST_IDLE);
    assign mem_req     = (state == ST_L1_REQ) || (state == ST_L2_REQ);
    assign mem_addr    = in_l1 ? l1_addr : (in_l2 ? l2_addr : '0);
    assign fill_valid  = (state == ST_FILL);
    assign fault_valid = (state == ST_FAULT);
    assign fault_level = lvl_q;
    assign fill_vbase  = rec_q.vbase;
    assign fill_pbase  = rec_q.pbase;
    assign fill_size   = rec_q.size;
    assign fill_ap     = rec_q.ap;
    assign fill_domain = rec_q.domain;
    assign fill_cb     = rec_q.cb;

    assign unused_l1_bits = ^l1_q[COARSE_BASE_LO-1:0];
endmodule

// File: rtl/xw_chk.sv
module xw_chk (
    input logic        clk,
    input logic        rst,
    input logic        miss_valid,
    input logic        busy,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_ack,
    input logic        fill_valid,
    input logic        fault_valid
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !fill_valid && !fault_valid));

    assert_walk_start_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && miss_valid) |=> (busy && mem_req));

    assert_one_result_R8: assert property (@(posedge clk) disable iff (rst)
        !(fill_valid && fault_valid));

    assert_req_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    assert_addr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_req && !mem_ack && !fill_valid && !fault_valid) |=> $stable(mem_addr));

    assert_result_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (fill_valid || fault_valid) |-> busy);

    assert_back_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (fill_valid || fault_valid) |=> !busy);
endmodule

bind xlate_walker xw_chk i_chk (.*);

// File: tb/test_xlate_walker.sv
module test_xlate_walker;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        bit          fault;
        bit          lvl;
        logic [31:0] vbase;
        logic [31:0] pbase;
        logic [1:0]  size;
        logic [1:0]  ap;
        logic [3:0]  dom;
        logic [1:0]  cb;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        miss_valid = 1'b0;
    logic [31:0] miss_va = '0;
    logic [31:0] ttb = '0;
    logic        busy, mem_req, mem_ack, fill_valid, fault_valid, fault_level;
    logic [31:0] mem_addr, mem_rdata, fill_vbase, fill_pbase;
    logic [1:0]  fill_size, fill_ap, fill_cb;
    logic [3:0]  fill_domain;

    exp_t        exp_q[$];
    logic [31:0] addr_q[$];
    string       atag_q[$];
    logic [31:0] mem_model [logic [31:0]];
    int          mem_lat = 1;
    int          n_checks = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlate_walker i_xlate_walker (
        .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_va(miss_va), .ttb(ttb),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .fill_valid(fill_valid), .fill_vbase(fill_vbase),
        .fill_pbase(fill_pbase), .fill_size(fill_size), .fill_ap(fill_ap),
        .fill_domain(fill_domain), .fill_cb(fill_cb), .fault_valid(fault_valid),
        .fault_level(fault_level)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // expected values straight from the requirements
    function automatic logic [31:0] l1_at(input logic [31:0] t, input logic [31:0] va);
        return {t[31:14], va[31:20], 2'b00};
    endfunction
    function automatic logic [31:0] coarse_at(input logic [31:0] d, input logic [31:0] va);
        return {d[31:10], va[19:12], 2'b00};
    endfunction
    function automatic logic [31:0] fine_at(input logic [31:0] d, input logic [31:0] va);
        return {d[31:12], va[19:10], 2'b00};
    endfunction
    function automatic exp_t sec_exp(input logic [31:0] va, input logic [31:0] d);
        exp_t e;
        e.fault = 0; e.lvl = 0; e.tag = "R4";
        e.vbase = {va[31:20], 20'h0};
        e.pbase = {d[31:20], 20'h0};
        e.size = 2'd0; e.ap = d[11:10]; e.dom = d[8:5]; e.cb = d[3:2];
        return e;
    endfunction
    function automatic exp_t page_exp(input logic [31:0] va, input logic [31:0] d1,
                                      input logic [31:0] d2, input logic [1:0] sz);
        exp_t e;
        logic [31:0] m;
        m = (sz == 2'd1) ? 32'hFFFF_0000 : (sz == 2'd2) ? 32'hFFFF_F000 : 32'hFFFF_FC00;
        e.fault = 0; e.lvl = 0; e.tag = "R7";
        e.vbase = va & m; e.pbase = d2 & m;
        e.size = sz; e.ap = d2[5:4]; e.dom = d1[8:5]; e.cb = d2[3:2];
        return e;
    endfunction
    function automatic exp_t fault_exp(input bit lvl);
        exp_t e;
        e = '{default: '0, tag: "R8"};
        e.fault = 1; e.lvl = lvl;
        return e;
    endfunction

    // memory stub: checks each read address when its strobe shows up
    initial begin
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (!rst && mem_req) begin
                logic [31:0] a;
                logic [31:0] d;
                a = mem_addr;
                if (addr_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected read", a, 32'h0);
                end else begin
                    logic [31:0] ea;
                    string       tg;
                    ea = addr_q.pop_front();
                    tg = atag_q.pop_front();
                    check(a == ea, tg, "read address", a, ea);
                end
                d = mem_model.exists(a) ? mem_model[a] : 32'h0;
                repeat (mem_lat - 1) begin
                    @(negedge clk);
                    check(!mem_req && mem_addr == a, "R9", "address held while waiting",
                          mem_addr, a);
                end
                @(negedge clk);
                mem_ack = 1'b1;
                mem_rdata = d;
            end
        end
    end

    // monitor: pops the expected result when a strobe appears
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && (fill_valid || fault_valid)) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected result", {31'h0, fill_valid}, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(fill_valid == !e.fault && fault_valid == e.fault, "R3",
                          "result kind", {30'h0, fault_valid, fill_valid},
                          {30'h0, e.fault, !e.fault});
                    if (e.fault) begin
                        check(fault_level == e.lvl, e.tag, "fault level",
                              {31'h0, fault_level}, {31'h0, e.lvl});
                    end else begin
                        check(fill_vbase == e.vbase, e.tag, "vbase", fill_vbase, e.vbase);
                        check(fill_pbase == e.pbase, e.tag, "pbase", fill_pbase, e.pbase);
                        check({fill_size, fill_ap, fill_domain, fill_cb} ==
                              {e.size, e.ap, e.dom, e.cb}, e.tag, "size/ap/domain/cb",
                              {22'h0, fill_size, fill_ap, fill_domain, fill_cb},
                              {22'h0, e.size, e.ap, e.dom, e.cb});
                    end
                end
            end
        end
    end

    task automatic run_walk(input logic [31:0] va, input logic [31:0] t, input int lat,
                            input exp_t e, input bit two, input logic [31:0] a2,
                            input string a2tag, input bit spur);
        int n;
        int exp_n;
        mem_lat = lat;
        addr_q.push_back(l1_at(t, va));
        atag_q.push_back("R2");
        if (two) begin
            addr_q.push_back(a2);
            atag_q.push_back(a2tag);
        end
        exp_q.push_back(e);
        @(negedge clk);
        miss_valid = 1'b1;
        miss_va = va;
        ttb = t;
        @(negedge clk);
        n = 1;
        miss_valid = spur;                 // R9: a miss during the walk must be ignored
        miss_va = va ^ 32'hFFF0_0000;
        while (!(fill_valid || fault_valid) && n < 100) begin
            check(busy, "R10", "busy during walk", {31'h0, busy}, 32'h1);
            @(negedge clk);
            miss_valid = 1'b0;
            n++;
        end
        exp_n = two ? 2 * lat + 3 : lat + 2;
        check(n == exp_n, "R10", "result cycle", n, exp_n);
        check(busy, "R10", "busy in result cycle", {31'h0, busy}, 32'h1);
        @(negedge clk);
        check(!busy && !fill_valid && !fault_valid, "R10", "idle after result",
              {29'h0, busy, fill_valid, fault_valid}, 32'h0);
        check(addr_q.size() == 0, "R9", "one read per level", addr_q.size(), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !mem_req && !fill_valid && !fault_valid, "R1", "reset outputs",
              {28'h0, busy, mem_req, fill_valid, fault_valid}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !mem_req, "R1", "idle after reset", {30'h0, busy, mem_req}, 32'h0);

        begin : walks
            logic [31:0] t, va, d1, d2;

            // R4 section, latency 1
            t = 32'h0004_0000; va = 32'h1234_5678;
            d1 = 32'h8760_0000 | (2'b11 << 10) | (4'hA << 5) | (2'b01 << 2) | 2'b10;
            mem_model[l1_at(t, va)] = d1;
            run_walk(va, t, 1, sec_exp(va, d1), 0, 32'h0, "", 0);

            // R5 R7 coarse -> small page; R2 ttb low bits set
            t = 32'h0010_3FFF; va = 32'hABCD_E123;
            d1 = 32'h0076_5400 | (4'h3 << 5) | 2'b01;
            d2 = 32'h5555_6000 | (2'b10 << 4) | (2'b11 << 2) | 2'b10;
            mem_model[l1_at(t, va)] = d1;
            mem_model[coarse_at(d1, va)] = d2;
            run_walk(va, t, 2, page_exp(va, d1, d2, 2'd2), 1, coarse_at(d1, va), "R5", 0);

            // R7 coarse -> large page
            t = 32'h0020_0000; va = 32'h0F0F_A5A5;
            d1 = 32'h0123_4C00 | (4'h9 << 5) | 2'b01;
            d2 = 32'h7777_0000 | (2'b01 << 4) | (2'b10 << 2) | 2'b01;
            mem_model[l1_at(t, va)] = d1;
            mem_model[coarse_at(d1, va)] = d2;
            run_walk(va, t, 1, page_exp(va, d1, d2, 2'd1), 1, coarse_at(d1, va), "R5", 0);

            // R8 tiny page reached through a coarse table faults at level two
            t = 32'h0030_0000; va = 32'h4444_4444;
            d1 = 32'h0200_0800 | 2'b01;
            d2 = 32'h9999_9C00 | 2'b11;
            mem_model[l1_at(t, va)] = d1;
            mem_model[coarse_at(d1, va)] = d2;
            run_walk(va, t, 2, fault_exp(1), 1, coarse_at(d1, va), "R5", 0);

            // R6 R7 fine -> tiny page, latency 3
            t = 32'h0040_C000; va = 32'h7654_3BCD;
            d1 = 32'h0345_6000 | (4'h6 << 5) | 2'b11;
            d2 = 32'hABCD_EC00 | (2'b11 << 4) | (2'b01 << 2) | 2'b11;
            mem_model[l1_at(t, va)] = d1;
            mem_model[fine_at(d1, va)] = d2;
            run_walk(va, t, 3, page_exp(va, d1, d2, 2'd3), 1, fine_at(d1, va), "R6", 0);

            // R6 R7 fine -> small page
            t = 32'h0050_0000; va = 32'h89AB_CDEF;
            d1 = 32'h0456_7000 | (4'hF << 5) | 2'b11;
            d2 = 32'h1357_9000 | (2'b00 << 4) | (2'b11 << 2) | 2'b10;
            mem_model[l1_at(t, va)] = d1;
            mem_model[fine_at(d1, va)] = d2;
            run_walk(va, t, 1, page_exp(va, d1, d2, 2'd2), 1, fine_at(d1, va), "R6", 0);

            // R8 first-level fault, R9 spurious miss during the walk
            t = 32'h0060_0000; va = 32'hFEDC_BA98;
            mem_model[l1_at(t, va)] = 32'hFFFF_FFFC;
            run_walk(va, t, 2, fault_exp(0), 0, 32'h0, "", 1);

            // R8 second-level fault in a fine table, R9 spurious miss
            t = 32'h0070_0000; va = 32'h0000_1400;
            d1 = 32'h0567_8000 | 2'b11;
            mem_model[l1_at(t, va)] = d1;
            mem_model[fine_at(d1, va)] = 32'hFFFF_FFF0;
            run_walk(va, t, 1, fault_exp(1), 1, fine_at(d1, va), "R6", 1);

            // R4 second section, latency 3, after a fault
            t = 32'h0080_4000; va = 32'hFFFF_FFFF;
            d1 = 32'h0010_0000 | (2'b01 << 10) | (4'h1 << 5) | (2'b10 << 2) | 2'b10;
            mem_model[l1_at(t, va)] = d1;
            run_walk(va, t, 3, sec_exp(va, d1), 0, 32'h0, "", 1);
        end

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R10", "all results seen", exp_q.size(), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule